// File: doc/BRIEF.md
# Pin Bank Controller with Interrupt Detection

This block controls a bank of general-purpose pins from a 32-bit register bus. For each pin it holds an output value and a drive enable, and it brings back a synchronised sample of the input. Each pin can also raise an interrupt in two ways. In level mode the request follows the pin continuously and is active either high or low. In edge mode a rising or falling transition is latched into an event register, which software clears by writing ones.

The bus reaches two register windows, chosen by `bus_win`. Window 0 is the per-pin bank. Window 1 is a small summary window. It holds one read-only flag that is set while any pin is pending, and one enable bit that gates the flag onto the single shared interrupt line. Reads are combinational on the address. Writes take effect at the rising clock edge on which `bus_we` is high.

Top module: `pinbank_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Window 0 offset 0x00 returns the pin inputs through a two-flop synchroniser. A change that is set up before clock edge k reads back after edge k+1 and not before.
- R3: Window 0 offsets 0x04 (output value) and 0x08 (drive enable) are read/write. `pin_oe` equals the enable register, and a bit of `pin_out` is 1 only when both its value bit and its enable bit are 1.
- R4: Window 0 offsets 0x10 (level sense: 0 = active high, 1 = active low) and 0x14 (level enable) give a per-pin level request equal to (synchronised input XOR sense) AND enable. The request is not latched and drops as soon as the input returns.
- R5: Window 0 offset 0x24 selects the edge per pin (0 = rising, 1 = falling). A matching transition sets the pin's bit at offset 0x18 one clock after the synchronised sample changes. The opposite transition leaves the bit alone.
- R6: Writing to offset 0x18 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When a detected edge and a write-one clear of the same bit fall on the same clock edge, the bit stays set.
- R8: Window 0 offset 0x1C is the edge enable. A pin's edge request is event AND edge enable, and its pending state is the OR of its level and edge requests. Events latch even while their enable bit is 0.
- R9: Window 1 offset 0x20 bit 0 reads 1 while any pin is pending. That register ignores writes. Window 1 offset 0x24 bit 0 is a read/write enable, and `irq_out` is high only when both bits are 1.
- R10: Register bits at and above PINS read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_win | input | 1 | Window select: 0 pin bank, 1 summary |
| bus_addr | input | 8 | Byte offset within the window |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | PINS | Asynchronous pin inputs |
| pin_out | output | PINS | Output values, gated by the drive enable |
| pin_oe | output | PINS | Per-pin drive enable |
| irq_out | output | 1 | Shared interrupt request |

## Verification
Every write is taken at the clock edge inside its strobe, and read data follows the address in the same cycle. Register readback and `pin_out` are therefore checked at the next falling edge after a write. A pin change set up before edge k reaches the input register, the level request and `irq_out` after edge k+1, and the edge event follows one edge later, after edge k+2. The bench drives every pin change at a falling edge and waits exactly two or three falling edges before it samples. It also checks one falling edge earlier that the result has not arrived yet. For the same-edge collision, the clear is issued so that its capture edge is the one on which the event is detected.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // pin bank window (bus_win = 0)
  localparam logic [ADDR_W-1:0] OFS_IN     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_OE     = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_LSENSE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_LEN    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EVT    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EEN    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_ESEL   = 8'h24;

  // summary window (bus_win = 1)
  localparam logic [ADDR_W-1:0] OFS_SUMSTS = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SUMEN  = 8'h24;

  // level request: mismatch against the sense bit, gated by enable
  function automatic logic [DATA_W-1:0] level_req(input logic [DATA_W-1:0] smp,
                                                  input logic [DATA_W-1:0] sense,
                                                  input logic [DATA_W-1:0] en);
    return (smp ^ sense) & en;
  endfunction

  // transition detect: sel 0 keeps rising, sel 1 keeps falling
  function automatic logic [DATA_W-1:0] edge_seen(input logic [DATA_W-1:0] now_v,
                                                  input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] sel);
    logic [DATA_W-1:0] up, down;
    up   = now_v & ~old_v;
    down = ~now_v & old_v;
    return (up & ~sel) | (down & sel);
  endfunction

  // event update: a new edge wins over a clear on the same edge
  function automatic logic [DATA_W-1:0] event_next(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] clr,
                                                   input logic [DATA_W-1:0] hit);
    return (cur & ~clr) | hit;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_async[i];
        stab_q <= meta_q;
      end
    end
    assign d_sync[i] = stab_q;
  end
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge
  import pinbank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] event_q
);
  logic [W-1:0]      prev_q;
  logic [DATA_W-1:0] smp_w, prev_w, sel_w, clr_w, evt_w, hit_w, nxt_w;

  always_comb begin
    smp_w  = '0; smp_w[W-1:0]  = smp;
    prev_w = '0; prev_w[W-1:0] = prev_q;
    sel_w  = '0; sel_w[W-1:0]  = sel;
    clr_w  = '0; clr_w[W-1:0]  = clr;
    evt_w  = '0; evt_w[W-1:0]  = event_q;
    hit_w  = edge_seen(smp_w, prev_w, sel_w);
    nxt_w  = event_next(evt_w, clr_w, hit_w);
  end

  assign hit = hit_w[W-1:0];

  logic unused_hi;
  assign unused_hi = ^{hit_w, nxt_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      event_q <= '0;
    end else begin
      prev_q  <= smp;
      event_q <= nxt_w[W-1:0];
    end
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   oe_q,
  output logic [PINS-1:0]   lsense_q,
  output logic [PINS-1:0]   len_q,
  output logic [PINS-1:0]   een_q,
  output logic [PINS-1:0]   esel_q,
  output logic              sum_en_q,
  output logic [PINS-1:0]   clr
);
  logic            wr_bank, wr_sum;
  logic [PINS-1:0] wd;

  assign wr_bank = we && !win;
  assign wr_sum  = we && win;
  assign wd      = wdata[PINS-1:0];
  assign clr     = (wr_bank && addr == OFS_EVT) ? wd : '0;

  logic unused_wd;
  assign unused_wd = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      oe_q     <= '0;
      lsense_q <= '0;
      len_q    <= '0;
      een_q    <= '0;
      esel_q   <= '0;
      sum_en_q <= 1'b0;
    end else begin
      if (wr_bank) begin
        case (addr)
          OFS_OUT:    out_q    <= wd;
          OFS_OE:     oe_q     <= wd;
          OFS_LSENSE: lsense_q <= wd;
          OFS_LEN:    len_q    <= wd;
          OFS_EEN:    een_q    <= wd;
          OFS_ESEL:   esel_q   <= wd;
          default: ;
        endcase
      end
      if (wr_sum && addr == OFS_SUMEN) sum_en_q <= wdata[0];
    end
  end
endmodule

// File: rtl/pinbank_irq_ctrl.sv
module pinbank_irq_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_win,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq_out
);
  logic [PINS-1:0] smp;
  logic [PINS-1:0] out_q, oe_q, lsense_q, len_q, een_q, esel_q;
  logic            sum_en_q;
  logic [PINS-1:0] clr_vec, hit_vec, event_q;
  logic [PINS-1:0] pend_vec;
  logic            any_pending;
  logic            sum_mask_q;

  pinbank_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(smp)
  );

  pinbank_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .win(bus_win), .addr(bus_addr),
    .we(bus_we), .wdata(bus_wdata),
    .out_q(out_q), .oe_q(oe_q), .lsense_q(lsense_q), .len_q(len_q),
    .een_q(een_q), .esel_q(esel_q), .sum_en_q(sum_en_q), .clr(clr_vec)
  );

  pinbank_edge #(.W(PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .smp(smp), .sel(esel_q), .clr(clr_vec),
    .hit(hit_vec), .event_q(event_q)
  );

  // widen to bus width
  logic [DATA_W-1:0] smp_w, out_w, oe_w, ls_w, len_w, evt_w, een_w, esel_w, lvl_w;
  always_comb begin
    smp_w  = '0; smp_w[PINS-1:0]  = smp;
    out_w  = '0; out_w[PINS-1:0]  = out_q;
    oe_w   = '0; oe_w[PINS-1:0]   = oe_q;
    ls_w   = '0; ls_w[PINS-1:0]   = lsense_q;
    len_w  = '0; len_w[PINS-1:0]  = len_q;
    evt_w  = '0; evt_w[PINS-1:0]  = event_q;
    een_w  = '0; een_w[PINS-1:0]  = een_q;
    esel_w = '0; esel_w[PINS-1:0] = esel_q;
    lvl_w  = level_req(smp_w, ls_w, len_w);
  end

  logic unused_lvl;
  assign unused_lvl = ^lvl_w;

  assign pend_vec    = lvl_w[PINS-1:0] | (event_q & een_q);
  assign any_pending = |pend_vec;
  assign sum_mask_q  = sum_en_q;
  assign irq_out     = any_pending && sum_mask_q;

  assign pin_out = out_q & oe_q;
  assign pin_oe  = oe_q;

  always_comb begin
    bus_rdata = '0;
    if (!bus_win) begin
      case (bus_addr)
        OFS_IN:     bus_rdata = smp_w;
        OFS_OUT:    bus_rdata = out_w;
        OFS_OE:     bus_rdata = oe_w;
        OFS_LSENSE: bus_rdata = ls_w;
        OFS_LEN:    bus_rdata = len_w;
        OFS_EVT:    bus_rdata = evt_w;
        OFS_EEN:    bus_rdata = een_w;
        OFS_ESEL:   bus_rdata = esel_w;
        default:    bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFS_SUMSTS: bus_rdata[0] = any_pending;
        OFS_SUMEN:  bus_rdata[0] = sum_mask_q;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pinbank_irq_ctrl_chk.sv
module pinbank_irq_ctrl_chk #(
  parameter int unsigned PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [31:0]     bus_rdata,
  input logic            sum_mask_q,
  input logic            any_pending,
  input logic [PINS-1:0] hit_vec,
  input logic [PINS-1:0] clr_vec,
  input logic [PINS-1:0] event_q
);
  assert_drive_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((event_q & $past(hit_vec)) == $past(hit_vec)));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~hit_vec) != '0) |=> ((event_q & $past(clr_vec & ~hit_vec)) == '0));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q & ~$past(event_q) & ~$past(hit_vec)) == '0);

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & clr_vec) != '0) |=> ((event_q & $past(hit_vec & clr_vec)) == $past(hit_vec & clr_vec)));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (sum_mask_q && any_pending));

  if (PINS < 32) begin : g_hi
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> PINS) == '0);
  end
endmodule

bind pinbank_irq_ctrl pinbank_irq_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .pin_out(pin_out),
  .pin_oe(pin_oe), .bus_rdata(bus_rdata), .sum_mask_q(sum_mask_q),
  .any_pending(any_pending), .hit_vec(hit_vec), .clr_vec(clr_vec),
  .event_q(event_q)
);

// File: tb/pinbank_irq_ctrl_tb.sv
module pinbank_irq_ctrl_tb;
  localparam int PINS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_win = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out, pin_oe;
  logic            irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pinbank_irq_ctrl #(.PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic w, input logic [7:0] a, input logic [31:0] d);
    bus_win = w; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic w, input logic [7:0] a, output logic [31:0] d);
    bus_win = w; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  logic [31:0] v;

  task automatic t_reset();
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(0, 8'h04, v); check("R1 out reg", v, 0);
    rd(0, 8'h18, v); check("R1 event reg", v, 0);
    rd(1, 8'h24, v); check("R1 summary enable", v, 0);
    rd(1, 8'h20, v); check("R1 summary status", v, 0);
  endtask

  task automatic t_input_sync();
    pin_in = 16'h8001;
    settle(1); rd(0, 8'h00, v); check("R2 input not yet", v, 0);
    settle(1); rd(0, 8'h00, v); check("R2 input synced", v, 32'h8001);
    pin_in = '0; settle(3);
    wr(0, 8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_output();
    wr(0, 8'h04, 32'h0000_00A5);
    wr(0, 8'h08, 32'h0000_000F);
    rd(0, 8'h04, v); check("R3 out readback", v, 32'hA5);
    rd(0, 8'h08, v); check("R3 oe readback", v, 32'h0F);
    check("R3 pin_out gated", {16'b0, pin_out}, 32'h05);
    check("R3 pin_oe", {16'b0, pin_oe}, 32'h0F);
  endtask

  task automatic t_level();
    wr(1, 8'h24, 32'h1);
    wr(0, 8'h14, 32'h1);
    check("R4 idle no irq", {31'b0, irq_out}, 0);
    pin_in[0] = 1'b1;
    settle(1); check("R4 level not yet", {31'b0, irq_out}, 0);
    settle(1); check("R4 active-high irq", {31'b0, irq_out}, 1);
    pin_in[0] = 1'b0; settle(2);
    check("R4 not latched", {31'b0, irq_out}, 0);
    wr(0, 8'h10, 32'h1);
    check("R4 active-low irq", {31'b0, irq_out}, 1);
    wr(0, 8'h14, 32'h0);
    check("R4 disabled", {31'b0, irq_out}, 0);
    wr(0, 8'h10, 32'h0);
    wr(0, 8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    wr(0, 8'h1C, 32'h4);
    pin_in[2] = 1'b1;
    settle(2); rd(0, 8'h18, v); check("R5 event not yet", v, 0);
    settle(1); rd(0, 8'h18, v); check("R5 rising latched", v, 32'h4);
    check("R8 edge irq", {31'b0, irq_out}, 1);
    pin_in[2] = 1'b0; settle(3);
    wr(0, 8'h18, 32'h0);
    rd(0, 8'h18, v); check("R6 write zero keeps", v, 32'h4);
    wr(0, 8'h18, 32'h4);
    rd(0, 8'h18, v); check("R6 write one clears", v, 0);
    check("R6 irq dropped", {31'b0, irq_out}, 0);
    wr(0, 8'h24, 32'h4);
    pin_in[2] = 1'b1; settle(3);
    rd(0, 8'h18, v); check("R5 rise ignored in falling mode", v, 0);
    pin_in[2] = 1'b0; settle(3);
    rd(0, 8'h18, v); check("R5 falling latched", v, 32'h4);
    wr(0, 8'h18, 32'hFFFF_FFFF);
    wr(0, 8'h24, 32'h0);
  endtask

  task automatic t_collision();
    pin_in[3] = 1'b1; settle(3);
    pin_in[3] = 1'b0; settle(3);
    rd(0, 8'h18, v); check("R5 pin3 set", v, 32'h8);
    pin_in[3] = 1'b1; settle(2);
    wr(0, 8'h18, 32'h8);
    rd(0, 8'h18, v); check("R7 edge wins over clear", v, 32'h8);
    wr(0, 8'h18, 32'h8);
    rd(0, 8'h18, v); check("R7 later clear works", v, 0);
    pin_in[3] = 1'b0; settle(3);
  endtask

  task automatic t_event_mask();
    wr(0, 8'h1C, 32'h0);
    pin_in[5] = 1'b1; settle(3);
    rd(0, 8'h18, v); check("R8 latched while disabled", v, 32'h20);
    check("R8 no irq while disabled", {31'b0, irq_out}, 0);
    wr(0, 8'h1C, 32'h20);
    check("R8 irq once enabled", {31'b0, irq_out}, 1);
  endtask

  task automatic t_summary();
    wr(1, 8'h24, 32'h0);
    check("R9 gated off", {31'b0, irq_out}, 0);
    rd(1, 8'h20, v); check("R9 status still set", v, 1);
    wr(1, 8'h20, 32'h0);
    rd(1, 8'h20, v); check("R9 status ignores write", v, 1);
    rd(1, 8'h24, v); check("R9 enable unchanged", v, 0);
    wr(1, 8'h24, 32'hFFFF_FFFF);
    rd(1, 8'h24, v); check("R9 enable bit0 only", v, 1);
    check("R9 irq on", {31'b0, irq_out}, 1);
    wr(0, 8'h18, 32'h20);
    rd(1, 8'h20, v); check("R9 status clears", v, 0);
    pin_in[5] = 1'b0; settle(3);
  endtask

  task automatic t_upper();
    wr(0, 8'h04, 32'hFFFF_FFFF);
    rd(0, 8'h04, v); check("R10 upper out bits zero", v, 32'h0000_FFFF);
    wr(0, 8'h1C, 32'hFFFF_0000);
    rd(0, 8'h1C, v); check("R10 upper enable ignored", v, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    settle(2);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_input_sync();
    t_output();
    t_level();
    t_edge();
    t_collision();
    t_event_mask();
    t_summary();
    t_upper();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule